// File: doc/BRIEF.md
# Age-Counter Victim Selector for a Set-Associative Instruction Cache

This block holds the replacement state of a set-associative instruction cache and chooses the way to be refilled on a miss. Each way of each set has a small saturating age counter. A way that is used gets the top age value. All other ways drift down toward zero as the set is accessed. On a miss, the youngest-valued way (the one with the lowest age) among the ways the mask allows becomes the victim.

The cache front end drives one access per strobe: a set index, a hit flag and, on a hit, the way that hit. The victim is presented combinationally in the same cycle as the strobe, so the refill logic can act on it at once. The counters of the addressed set update at the next rising clock edge. Two global qualifiers, cache present and cache enabled, must both be high for an access to have any effect. A running cycle counter accumulates a fixed hit cost or miss cost per access, so the front end can account for cache latency. Tag and data storage and the refill itself belong to neighbouring blocks.

Top module: `way_age_lru`

## Requirements
- R1: An access has no effect when `acc_valid`, `cache_present` or `cache_enable` is low: no age counter and no part of `cycle_count` changes, and `victim_valid` is low.
- R2: On a hit, every way of the addressed set whose age is nonzero loses one. The way given by `acc_hit_way` is then set to the top age, USAGE_STATES-1.
- R3: On a miss, `victim_valid` is high in the same cycle as the strobe. `victim_way` is the way with the smallest age among the ways whose bit is 1 in `way_enable` (bit i is way i). The lowest way number wins a tie. When `way_enable` is all zero, the victim is way 0.
- R4: On a miss, a way's age decrements only if it is nonzero and its `way_enable` bit is 1. Disabled ways hold their age. The victim is then set to the top age.
- R5: At the rising edge that ends a hit strobe, `cycle_count` grows by HIT_DELAY. At the edge that ends a miss strobe, it grows by MISS_DELAY, wrapping modulo 2^CYC_W.
- R6: An access changes only the counters of the set it addresses.
- R7: A low `rst_n` clears every age counter and `cycle_count` to zero at once, without waiting for a clock edge.
- R8: Each age counter is ceil(log2(USAGE_STATES)) bits wide and never holds a value above USAGE_STATES-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cache_present | input | 1 | The cache exists; gates all activity |
| cache_enable | input | 1 | The cache is switched on; gates all activity |
| acc_valid | input | 1 | Fetch access strobe |
| acc_set | input | SET_W | Set index of the access |
| acc_hit | input | 1 | 1 = hit, 0 = miss |
| acc_hit_way | input | WAY_W | Way that hit (used only when acc_hit is 1) |
| way_enable | input | NUM_WAYS | Ways allowed to take part in a miss |
| victim_way | output | WAY_W | Way chosen for refill |
| victim_valid | output | 1 | A qualified miss is present this cycle |
| cycle_count | output | CYC_W | Accumulated access latency |

## Verification
The assertions check the following on every cycle:
- Idle or gated cycles leave the counters and `cycle_count` untouched.
- A hit or miss leaves the chosen way at the top age.
- Sets other than the addressed one keep their counters.
- The victim is an enabled way whose age is not above that of any other enabled way.
- No stored age exceeds the top value.
- `cycle_count` steps by exactly the hit or miss cost.

Some behaviour shows up only over a scripted history, so only the bench's scenarios can show it. This covers the aging order over many accesses, the lowest-way tie rule, the all-zero mask default, and the way a masked miss leaves disabled ways unaged. It also covers the proof, taken from later victim choices, that gated accesses changed nothing. The asynchronous clearing in the middle of a run is also shown there.

// File: rtl/lru_age_pkg.sv
package lru_age_pkg;

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_HIT  = 2'd1,
    ACC_MISS = 2'd2
  } acc_kind_e;

endpackage

// File: rtl/lru_victim_pick.sv
module lru_victim_pick #(
  parameter int NUM_WAYS = 4,
  parameter int CNT_W    = 2,
  parameter int WAY_W    = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NUM_WAYS-1:0][CNT_W-1:0]     row_age,
  input  logic [NUM_WAYS-1:0]                way_en,
  output logic [WAY_W-1:0]                   victim
);

  logic [CNT_W-1:0] best_age;
  logic             found;

  // Ascending scan with strict less-than: the lowest way wins a tie.
  always_comb begin
    best_age = {CNT_W{1'b1}};
    found    = 1'b0;
    victim   = '0;
    for (int w = 0; w < NUM_WAYS; w++) begin
      if (way_en[w] && (!found || (row_age[w] < best_age))) begin
        found    = 1'b1;
        best_age = row_age[w];
        victim   = WAY_W'(w);
      end
    end
  end

  // R3: an enabled way is picked whenever one exists
  assert_victim_enabled_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|way_en) |-> way_en[victim]);

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_min_chk
    // R3: no enabled way is younger-valued than the victim
    assert_victim_min_R3: assert property (@(posedge clk) disable iff (!rst_n)
      way_en[g] |-> (row_age[g] >= row_age[victim]));
  end

endmodule

// File: rtl/lru_row_update.sv
module lru_row_update
  import lru_age_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int CNT_W    = 2,
  parameter int WAY_W    = 2,
  parameter int MAX_AGE  = 3
) (
  input  acc_kind_e                          kind,
  input  logic [WAY_W-1:0]                   sel_way,
  input  logic [NUM_WAYS-1:0]                way_en,
  input  logic [NUM_WAYS-1:0][CNT_W-1:0]     row_in,
  output logic [NUM_WAYS-1:0][CNT_W-1:0]     row_out
);

  localparam logic [CNT_W-1:0] TOP = CNT_W'(MAX_AGE);

  for (genvar g = 0; g < NUM_WAYS; g++) begin : g_way
    logic may_dec;
    logic is_sel;

    always_comb begin
      may_dec = (kind == ACC_HIT) || ((kind == ACC_MISS) && way_en[g]);
      is_sel  = (kind != ACC_NONE) && (sel_way == WAY_W'(g));
      if (is_sel) begin
        row_out[g] = TOP;
      end else if (may_dec && (row_in[g] != '0)) begin
        row_out[g] = row_in[g] - 1'b1;
      end else begin
        row_out[g] = row_in[g];
      end
    end
  end

endmodule

// File: rtl/lru_age_store.sv
module lru_age_store #(
  parameter int NUM_SETS = 16,
  parameter int NUM_WAYS = 4,
  parameter int CNT_W    = 2,
  parameter int SET_W    = 4,
  parameter int MAX_AGE  = 3
) (
  input  logic                                          clk,
  input  logic                                          rst_n,
  input  logic                                          wr_en,
  input  logic [SET_W-1:0]                              wr_set,
  input  logic [NUM_WAYS-1:0][CNT_W-1:0]                wr_row,
  input  logic [SET_W-1:0]                              rd_set,
  output logic [NUM_WAYS-1:0][CNT_W-1:0]                rd_row,
  output logic [NUM_SETS-1:0][NUM_WAYS-1:0][CNT_W-1:0]  age_all
);

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic                           set_we;
    logic [NUM_WAYS-1:0][CNT_W-1:0] row_q;

    always_comb begin
      set_we = wr_en && (wr_set == SET_W'(s));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        row_q <= '0;
      end else if (set_we) begin
        row_q <= wr_row;
      end
    end

    assign age_all[s] = row_q;

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_rng
      // R8: a stored age never exceeds the top value
      assert_age_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        row_q[w] <= CNT_W'(MAX_AGE));
    end
  end

  assign rd_row = age_all[rd_set];

endmodule

// File: rtl/lru_cycle_accum.sv
module lru_cycle_accum
  import lru_age_pkg::*;
#(
  parameter int CYC_W      = 32,
  parameter int HIT_DELAY  = 1,
  parameter int MISS_DELAY = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  acc_kind_e        kind,
  output logic [CYC_W-1:0] cycle_count
);

  localparam logic [CYC_W-1:0] HIT_STEP  = CYC_W'(HIT_DELAY);
  localparam logic [CYC_W-1:0] MISS_STEP = CYC_W'(MISS_DELAY);

  logic [CYC_W-1:0] cyc_d;
  logic             cyc_en;

  always_comb begin
    cyc_en = (kind != ACC_NONE);
    cyc_d  = cycle_count + ((kind == ACC_HIT) ? HIT_STEP : MISS_STEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cycle_count <= '0;
    end else if (cyc_en) begin
      cycle_count <= cyc_d;
    end
  end

  // R5: a hit costs exactly HIT_DELAY
  assert_hit_cost_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_HIT) |=> (cycle_count == $past(cycle_count) + HIT_STEP));

  // R5: a miss costs exactly MISS_DELAY
  assert_miss_cost_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (kind == ACC_MISS) |=> (cycle_count == $past(cycle_count) + MISS_STEP));

endmodule

// File: rtl/way_age_lru.sv
module way_age_lru
  import lru_age_pkg::*;
#(
  parameter int NUM_WAYS     = 4,
  parameter int NUM_SETS     = 16,
  parameter int USAGE_STATES = 4,
  parameter int HIT_DELAY    = 1,
  parameter int MISS_DELAY   = 8,
  parameter int CYC_W        = 32,
  localparam int WAY_W       = (NUM_WAYS < 2) ? 1 : $clog2(NUM_WAYS),
  localparam int SET_W       = (NUM_SETS < 2) ? 1 : $clog2(NUM_SETS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cache_present,
  input  logic                cache_enable,
  input  logic                acc_valid,
  input  logic [SET_W-1:0]    acc_set,
  input  logic                acc_hit,
  input  logic [WAY_W-1:0]    acc_hit_way,
  input  logic [NUM_WAYS-1:0] way_enable,
  output logic [WAY_W-1:0]    victim_way,
  output logic                victim_valid,
  output logic [CYC_W-1:0]    cycle_count
);

  localparam int CNT_W   = (USAGE_STATES < 3) ? 1 : $clog2(USAGE_STATES);
  localparam int MAX_AGE = USAGE_STATES - 1;

  logic                                         active;
  acc_kind_e                                    kind;
  logic [WAY_W-1:0]                             sel_way;
  logic [NUM_WAYS-1:0][CNT_W-1:0]               cur_row;
  logic [NUM_WAYS-1:0][CNT_W-1:0]               new_row;
  logic [NUM_SETS-1:0][NUM_WAYS-1:0][CNT_W-1:0] age_all;

  always_comb begin
    active = cache_present && cache_enable && acc_valid;
    if (!active)      kind = ACC_NONE;
    else if (acc_hit) kind = ACC_HIT;
    else              kind = ACC_MISS;
    sel_way      = acc_hit ? acc_hit_way : victim_way;
    victim_valid = active && !acc_hit;
  end

  lru_age_store #(
    .NUM_SETS (NUM_SETS),
    .NUM_WAYS (NUM_WAYS),
    .CNT_W    (CNT_W),
    .SET_W    (SET_W),
    .MAX_AGE  (MAX_AGE)
  ) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (active),
    .wr_set  (acc_set),
    .wr_row  (new_row),
    .rd_set  (acc_set),
    .rd_row  (cur_row),
    .age_all (age_all)
  );

  lru_victim_pick #(
    .NUM_WAYS (NUM_WAYS),
    .CNT_W    (CNT_W),
    .WAY_W    (WAY_W)
  ) u_pick (
    .clk     (clk),
    .rst_n   (rst_n),
    .row_age (cur_row),
    .way_en  (way_enable),
    .victim  (victim_way)
  );

  lru_row_update #(
    .NUM_WAYS (NUM_WAYS),
    .CNT_W    (CNT_W),
    .WAY_W    (WAY_W),
    .MAX_AGE  (MAX_AGE)
  ) u_update (
    .kind    (kind),
    .sel_way (sel_way),
    .way_en  (way_enable),
    .row_in  (cur_row),
    .row_out (new_row)
  );

  lru_cycle_accum #(
    .CYC_W      (CYC_W),
    .HIT_DELAY  (HIT_DELAY),
    .MISS_DELAY (MISS_DELAY)
  ) u_cyc (
    .clk         (clk),
    .rst_n       (rst_n),
    .kind        (kind),
    .cycle_count (cycle_count)
  );

  // R1: a gated or idle cycle changes nothing
  assert_idle_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> ($stable(cycle_count) && $stable(age_all)));

  // R2: the way that hit ends at the top age
  assert_hit_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (active && acc_hit) |=>
      (age_all[$past(acc_set)][$past(acc_hit_way)] == CNT_W'(MAX_AGE)));

  // R4: the refilled victim ends at the top age
  assert_miss_top_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !acc_hit) |=>
      (age_all[$past(acc_set)][$past(victim_way)] == CNT_W'(MAX_AGE)));

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_iso
    // R6: sets not addressed keep their ages
    assert_other_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (active && (acc_set != SET_W'(s))) |=> $stable(age_all[s]));
  end

endmodule

// File: tb/test_way_age_lru.sv
module test_way_age_lru;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cache_present = 1'b0;
  logic        cache_enable = 1'b0;
  logic        acc_valid = 1'b0;
  logic [3:0]  acc_set = '0;
  logic        acc_hit = 1'b0;
  logic [1:0]  acc_hit_way = '0;
  logic [3:0]  way_enable = '0;
  logic [1:0]  victim_way;
  logic        victim_valid;
  logic [31:0] cycle_count;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  way_age_lru i_way_age_lru (
    .clk           (clk),
    .rst_n         (rst_n),
    .cache_present (cache_present),
    .cache_enable  (cache_enable),
    .acc_valid     (acc_valid),
    .acc_set       (acc_set),
    .acc_hit       (acc_hit),
    .acc_hit_way   (acc_hit_way),
    .way_enable    (way_enable),
    .victim_way    (victim_way),
    .victim_valid  (victim_valid),
    .cycle_count   (cycle_count)
  );

  typedef struct packed {
    logic        pr;
    logic        en;
    logic        vl;
    logic        hit;
    logic [3:0]  set;
    logic [1:0]  hway;
    logic [3:0]  mask;
    logic        evv;
    logic [1:0]  evic;
    logic [15:0] ecyc;
  } vec_t;

  // Defaults: 4 ways, top age 3, hit cost 1, miss cost 8. Ages of set 0 in comments.
  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    '{1,1,1,0, 4'd0, 2'd0, 4'hF, 1, 2'd0, 16'd8  },  // R3 all-zero tie -> w0: 3000
    '{1,1,1,0, 4'd0, 2'd0, 4'hF, 1, 2'd1, 16'd16 },  // 2300
    '{1,1,1,0, 4'd0, 2'd0, 4'hF, 1, 2'd2, 16'd24 },  // 1230
    '{1,1,1,0, 4'd0, 2'd0, 4'hF, 1, 2'd3, 16'd32 },  // 0123
    '{1,1,1,1, 4'd0, 2'd2, 4'hF, 0, 2'd0, 16'd33 },  // R2 hit w2: 0032
    '{1,1,1,0, 4'd0, 2'd0, 4'hF, 1, 2'd0, 16'd41 },  // tie w0/w1: 3021
    '{1,1,1,0, 4'd0, 2'd0, 4'hC, 1, 2'd3, 16'd49 },  // R4 mask: 3013
    '{0,1,1,0, 4'd0, 2'd0, 4'hF, 0, 2'd0, 16'd49 },  // R1 not present
    '{1,0,1,1, 4'd0, 2'd1, 4'hF, 0, 2'd0, 16'd49 },  // R1 not enabled
    '{1,1,1,0, 4'd0, 2'd0, 4'hF, 1, 2'd1, 16'd57 },  // 2302
    '{1,1,1,0, 4'd5, 2'd0, 4'hF, 1, 2'd0, 16'd65 },  // R6 fresh set 5
    '{1,1,1,0, 4'd0, 2'd0, 4'h2, 1, 2'd1, 16'd73 },  // single way enabled
    '{1,1,1,0, 4'd0, 2'd0, 4'h0, 1, 2'd0, 16'd81 },  // empty mask -> w0: 3302
    '{1,1,1,1, 4'd0, 2'd3, 4'hF, 0, 2'd0, 16'd82 },  // R2: 2203
    '{1,1,1,0, 4'd0, 2'd0, 4'hF, 1, 2'd2, 16'd90 },  // 1132
    '{1,1,1,0, 4'd0, 2'd0, 4'h3, 1, 2'd0, 16'd98 },  // tie in mask: 3032
    '{1,1,1,0, 4'd0, 2'd0, 4'hF, 1, 2'd1, 16'd106},  // 2321
    '{1,1,1,1, 4'd0, 2'd1, 4'hF, 0, 2'd0, 16'd107},  // R2 top way hit again: 1310
    '{1,1,1,0, 4'd0, 2'd0, 4'hF, 1, 2'd3, 16'd115},  // 0203
    '{1,1,1,0, 4'd0, 2'd0, 4'hF, 1, 2'd0, 16'd123},  // 3102
    '{1,1,0,0, 4'd0, 2'd0, 4'hF, 0, 2'd0, 16'd123},  // R1 no strobe
    '{1,1,1,0, 4'd0, 2'd0, 4'hF, 1, 2'd2, 16'd131}   // 2031
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    cache_present = v.pr;
    cache_enable  = v.en;
    acc_valid     = v.vl;
    acc_hit       = v.hit;
    acc_set       = v.set;
    acc_hit_way   = v.hway;
    way_enable    = v.mask;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R7 reset cycle_count", cycle_count, 0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      #1;
      check(VEC[i].evv ? "R3 victim_valid" : "R1 victim_valid low", 32'(victim_valid), 32'(VEC[i].evv));
      if (VEC[i].evv) check("R3/R4 victim_way", 32'(victim_way), 32'(VEC[i].evic));
      @(posedge clk);
      #1;
      check((VEC[i].pr && VEC[i].en && VEC[i].vl) ? "R5 cycle_count" : "R1 cycle_count held",
            cycle_count, 32'(VEC[i].ecyc));
    end

    // R7: asynchronous clear mid-run, seen before any clock edge
    @(negedge clk);
    acc_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R7 async clear cycle_count", cycle_count, 0);
    @(negedge clk);
    rst_n = 1'b1;
    // Set 0 was 2031 (victim would be w1); cleared ages give w0
    drive('{1,1,1,0, 4'd0, 2'd0, 4'hF, 1, 2'd0, 16'd8});
    #1;
    check("R7 ages cleared victim", 32'(victim_way), 0);
    @(posedge clk);
    #1;
    check("R5 miss cost after reset", cycle_count, 8);

    // R8/R2: repeated hits on one way keep it at top; neighbours drain to 0
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      drive('{1,1,1,1, 4'd0, 2'd0, 4'hF, 0, 2'd0, 16'd0});
    end
    @(negedge clk);
    drive('{1,1,1,0, 4'd0, 2'd0, 4'hE, 1, 2'd0, 16'd0});
    #1;
    check("R2 drained ways tie -> w1", 32'(victim_way), 1);
    @(negedge clk);
    drive('{1,1,1,0, 4'd0, 2'd0, 4'h1, 1, 2'd0, 16'd0});
    #1;
    check("R8 top way still victim when alone", 32'(victim_way), 0);
    @(posedge clk);
    #1;
    check("R5 total after hits", cycle_count, 8 + 4 + 8 + 8);
    @(negedge clk);
    acc_valid = 1'b0;
    @(posedge clk);
    finish_run();
  end

endmodule